// File: doc/BRIEF.md
# Single-Owner Coherence Directory Controller

This block keeps one directory entry per memory block and enforces a strict single-owner rule. At any moment a block lives in at most one cache, so copies in different caches can never disagree. Each entry holds three things: a flag saying whether some cache holds the block, an owner pointer naming that cache, and a modified flag saying whether the owner has written the block.

When a cache misses on a block, the controller first checks the entry. If another cache owns the block, the controller sends one directed message to that owner. The message tells the owner to drop its copy and, when the modified flag is set, also to write the block back to memory. The controller then grants the block to the requester and points the entry at it. The modified flag takes the requester's write intent. There is no broadcast: a new requester always takes the block from the one previous owner.

Each transaction is charged bus cycles under a pipelined bus cost model:
- the directory check costs 1 cycle;
- an invalidate message costs 1 cycle;
- a write-back of the four-word block costs 4 cycles;
- a fetch costs 5 cycles, 1 for the address and 4 for the data.

The controller spends exactly one clock in each charged step. The total is reported with the completion pulse.

States:
- `S_IDLE` accepts a request (`S_IDLE -> S_CHECK`).
- `S_CHECK` reads the entry. It goes to `S_FAULT` when the requester is already the owner, to `S_INVAL` when another cache owns the block, and to `S_FETCH` when no cache holds it.
- `S_INVAL` issues the message. It goes to `S_WBACK` when the block is modified and to `S_FETCH` otherwise.
- `S_WBACK` lasts four cycles and then goes to `S_FETCH`.
- `S_FETCH` lasts five cycles and then goes to `S_GRANT`.
- `S_GRANT` updates the entry and goes back to `S_IDLE`.
- `S_FAULT` flags the error and goes back to `S_IDLE`.

Top module: `excl_dir_ctrl`

## Requirements
- R1: After reset every entry records no owner, `req_ready` is 1, and `msg_valid`, `done_grant` and `done_error` are 0.
- R2: A miss on a block with no owner sends no message. It ends with `done_grant`=1, `done_from_wb`=0 and `done_cost`=6 (check 1 + fetch 5).
- R3: A miss on a block owned, unmodified, by another cache sends exactly one message to that owner with `msg_wb`=0. It ends with `done_cost`=7.
- R4: A miss on a block owned, modified, by another cache sends exactly one message to that owner with `msg_wb`=1. It ends with `done_from_wb`=1 and `done_cost`=11.
- R5: After a grant, the entry names the requester as owner, and its modified flag equals the `req_write` value of that request.
- R6: A miss from the cache that already owns the block sends no message. It ends with `done_error`=1, `done_grant`=0 and `done_cost`=1, and leaves the entry unchanged.
- R7: `req_ready` is 0 from the cycle after acceptance until the completion pulse has passed. The completion pulse (`done_grant` or `done_error`) lasts one cycle, and the two flags are never both 1.
- R8: A transaction changes only the entry of its own block.
- R9: A message is never addressed to the requesting cache. At most one message is sent per transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Controller idle; request accepted when both are 1 |
| req_cache | input | CACHE_W | Requesting cache index |
| req_block | input | BLOCK_W | Block index |
| req_write | input | 1 | 1 = write miss (new owner will modify the block) |
| msg_valid | output | 1 | Directed message to the previous owner |
| msg_cache | output | CACHE_W | Message destination cache |
| msg_wb | output | 1 | 1 = write back before dropping, 0 = drop only |
| done_grant | output | 1 | One-cycle pulse: block granted to the requester |
| done_error | output | 1 | One-cycle pulse: requester already owned the block |
| done_from_wb | output | 1 | With grant: the data came after a write-back |
| done_cost | output | COST_W | Bus cycles charged to this transaction |

## Verification
The assertions assume that requests arrive only while `req_ready` is 1. They also assume that request fields are held stable in the accepting cycle. The bench drives each request for exactly one cycle at a falling edge while the controller is idle. It then waits for the completion pulse before issuing the next request, so no request overlaps another. The cache and block indices used are always inside the parameter ranges.

// File: rtl/excl_dir_pkg.sv
package excl_dir_pkg;
    localparam int CHECK_CYC = 1;
    localparam int INVAL_CYC = 1;
    localparam int WBACK_CYC = 4;
    localparam int FETCH_CYC = 5;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_INVAL,
        S_WBACK,
        S_FETCH,
        S_GRANT,
        S_FAULT
    } dir_state_e;
endpackage

// File: rtl/excl_dir_table.sv
module excl_dir_table #(
    parameter int NUM_BLOCKS = 16,
    parameter int CACHE_W    = 2,
    localparam int BLOCK_W   = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BLOCK_W-1:0] rd_block,
    output logic               rd_held,
    output logic [CACHE_W-1:0] rd_owner,
    output logic               rd_mod,
    input  logic               wr_en,
    input  logic [BLOCK_W-1:0] wr_block,
    input  logic [CACHE_W-1:0] wr_owner,
    input  logic               wr_mod
);
    logic               held_q  [NUM_BLOCKS];
    logic [CACHE_W-1:0] owner_q [NUM_BLOCKS];
    logic               mod_q   [NUM_BLOCKS];

    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held_q[g]  <= 1'b0;
                owner_q[g] <= '0;
                mod_q[g]   <= 1'b0;
            end else if (wr_en && (wr_block == BLOCK_W'(g))) begin
                held_q[g]  <= 1'b1;
                owner_q[g] <= wr_owner;
                mod_q[g]   <= wr_mod;
            end
        end
    end

    always_comb begin
        rd_held  = held_q[rd_block];
        rd_owner = owner_q[rd_block];
        rd_mod   = mod_q[rd_block];
    end
endmodule

// File: rtl/excl_dir_cost.sv
module excl_dir_cost #(
    parameter int COST_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              charge,
    output logic [COST_W-1:0] total
);
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            total <= '0;
        end else if (charge) begin
            total <= total + COST_W'(1);
        end
    end
endmodule

// File: rtl/excl_dir_ctrl.sv
module excl_dir_ctrl
    import excl_dir_pkg::*;
#(
    parameter int NUM_CACHES = 4,
    parameter int NUM_BLOCKS = 16,
    parameter int COST_W     = 5,
    localparam int CACHE_W   = (NUM_CACHES > 1) ? $clog2(NUM_CACHES) : 1,
    localparam int BLOCK_W   = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [CACHE_W-1:0] req_cache,
    input  logic [BLOCK_W-1:0] req_block,
    input  logic               req_write,
    output logic               msg_valid,
    output logic [CACHE_W-1:0] msg_cache,
    output logic               msg_wb,
    output logic               done_grant,
    output logic               done_error,
    output logic               done_from_wb,
    output logic [COST_W-1:0]  done_cost
);
    localparam int BEAT_W = 3;

    dir_state_e         state_q, state_d;
    logic [BEAT_W-1:0]  beat_q;
    logic [CACHE_W-1:0] cur_cache;
    logic [BLOCK_W-1:0] cur_block;
    logic               cur_write;
    logic               wb_seen_q;

    logic               ent_held;
    logic [CACHE_W-1:0] ent_owner;
    logic               ent_mod;
    logic               accept;
    logic               charge;
    logic [COST_W-1:0]  cost_total;

    assign accept = req_valid && (state_q == S_IDLE);
    assign charge = (state_q == S_CHECK) || (state_q == S_INVAL) ||
                    (state_q == S_WBACK) || (state_q == S_FETCH);

    excl_dir_table #(
        .NUM_BLOCKS(NUM_BLOCKS),
        .CACHE_W   (CACHE_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_block(cur_block),
        .rd_held (ent_held),
        .rd_owner(ent_owner),
        .rd_mod  (ent_mod),
        .wr_en   (state_q == S_GRANT),
        .wr_block(cur_block),
        .wr_owner(cur_cache),
        .wr_mod  (cur_write)
    );

    excl_dir_cost #(.COST_W(COST_W)) u_cost (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .charge(charge),
        .total (cost_total)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req_valid) state_d = S_CHECK;
            S_CHECK: begin
                if (ent_held && ent_owner == cur_cache) state_d = S_FAULT;
                else if (ent_held)                      state_d = S_INVAL;
                else                                    state_d = S_FETCH;
            end
            S_INVAL: state_d = ent_mod ? S_WBACK : S_FETCH;
            S_WBACK: if (beat_q == BEAT_W'(WBACK_CYC - 1)) state_d = S_FETCH;
            S_FETCH: if (beat_q == BEAT_W'(FETCH_CYC - 1)) state_d = S_GRANT;
            S_GRANT: state_d = S_IDLE;
            S_FAULT: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register, beat counter and captured request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            beat_q    <= '0;
            cur_cache <= '0;
            cur_block <= '0;
            cur_write <= 1'b0;
            wb_seen_q <= 1'b0;
        end else begin
            state_q <= state_d;
            beat_q  <= (state_d != state_q) ? '0 : beat_q + BEAT_W'(1);
            if (accept) begin
                cur_cache <= req_cache;
                cur_block <= req_block;
                cur_write <= req_write;
                wb_seen_q <= 1'b0;
            end else if (state_q == S_WBACK) begin
                wb_seen_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready    = (state_q == S_IDLE);
        msg_valid    = (state_q == S_INVAL);
        msg_cache    = ent_owner;
        msg_wb       = ent_mod;
        done_grant   = (state_q == S_GRANT);
        done_error   = (state_q == S_FAULT);
        done_from_wb = (state_q == S_GRANT) && wb_seen_q;
        done_cost    = cost_total;
    end
endmodule

// File: rtl/excl_dir_checker.sv
module excl_dir_checker #(
    parameter int CACHE_W = 2,
    parameter int COST_W  = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_ready,
    input logic               msg_valid,
    input logic [CACHE_W-1:0] msg_cache,
    input logic [CACHE_W-1:0] cur_cache,
    input logic               done_grant,
    input logic               done_error,
    input logic               done_from_wb,
    input logic [COST_W-1:0]  done_cost
);
    AST_GRANT_COST: assert property (@(posedge clk) disable iff (!rst_n)
        done_grant |-> (done_cost == COST_W'(6) || done_cost == COST_W'(7) || done_cost == COST_W'(11))); // R3
    AST_WB_COST: assert property (@(posedge clk) disable iff (!rst_n)
        (done_grant && done_from_wb) |-> done_cost == COST_W'(11)); // R4
    AST_FAULT_COST: assert property (@(posedge clk) disable iff (!rst_n)
        done_error |-> done_cost == COST_W'(1)); // R6
    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_grant && done_error)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_grant || done_error) |=> (req_ready && !done_grant && !done_error)); // R7
    AST_MSG_NOT_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> msg_cache != cur_cache); // R9
    AST_MSG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |=> !msg_valid); // R9
endmodule

bind excl_dir_ctrl excl_dir_checker #(
    .CACHE_W(CACHE_W),
    .COST_W (COST_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .msg_valid   (msg_valid),
    .msg_cache   (msg_cache),
    .cur_cache   (cur_cache),
    .done_grant  (done_grant),
    .done_error  (done_error),
    .done_from_wb(done_from_wb),
    .done_cost   (done_cost)
);

// File: tb/excl_dir_ctrl_test.sv
module excl_dir_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_cache = '0;
    logic [3:0] req_block = '0;
    logic       req_write = 1'b0;
    logic       msg_valid;
    logic [1:0] msg_cache;
    logic       msg_wb;
    logic       done_grant, done_error, done_from_wb;
    logic [4:0] done_cost;

    int checks = 0;
    int errors = 0;

    int n_msg;
    int last_msg_cache;
    int last_msg_wb;

    always #(CLK_PERIOD / 2) clk = ~clk;

    excl_dir_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_cache(req_cache), .req_block(req_block), .req_write(req_write),
        .msg_valid(msg_valid), .msg_cache(msg_cache), .msg_wb(msg_wb),
        .done_grant(done_grant), .done_error(done_error),
        .done_from_wb(done_from_wb), .done_cost(done_cost)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Issue one miss and check its message and completion.
    // exp_msg: -1 = no message, else the owner that must be told.
    task automatic miss(input int c, input int b, input bit wr,
                        input int exp_msg, input int exp_wb,
                        input bit exp_err, input int exp_cost, input string tag);
        bit done = 0;
        n_msg = 0;
        last_msg_cache = -1;
        last_msg_wb = -1;
        @(negedge clk);
        req_valid = 1'b1;
        req_cache = 2'(c);
        req_block = 4'(b);
        req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R7 ready low when busy"}, int'(req_ready), 0);
        for (int i = 0; i < 40 && !done; i++) begin
            if (msg_valid) begin
                n_msg++;
                last_msg_cache = int'(msg_cache);
                last_msg_wb = int'(msg_wb);
            end
            if (done_grant || done_error) done = 1;
            else @(negedge clk);
        end
        check({tag, " watchdog"}, int'(done), 1);
        if (done) begin
            check({tag, " R9 message count"}, n_msg, (exp_msg < 0) ? 0 : 1);
            if (exp_msg >= 0) begin
                check({tag, " R3 message target"}, last_msg_cache, exp_msg);
                check({tag, " R4 message write-back flag"}, last_msg_wb, exp_wb);
            end
            check({tag, " R6 error flag"}, int'(done_error), int'(exp_err));
            check({tag, " R7 grant flag"}, int'(done_grant), int'(!exp_err));
            check({tag, " R2 cost"}, int'(done_cost), exp_cost);
            if (!exp_err)
                check({tag, " R4 from write-back"}, int'(done_from_wb), exp_wb == 1 ? 1 : 0);
            @(negedge clk);
            check({tag, " R7 pulse ends"}, int'(done_grant || done_error), 0);
            check({tag, " R7 ready again"}, int'(req_ready), 1);
        end
    endtask

    task automatic t_reset;
        check("R1 ready after reset", int'(req_ready), 1);
        check("R1 no message after reset", int'(msg_valid), 0);
        check("R1 no done after reset", int'(done_grant || done_error), 0);
    endtask

    task automatic t_uncached;
        miss(1, 3, 1'b0, -1, 0, 1'b0, 6, "R2 uncached block 3");
        miss(0, 0, 1'b1, -1, 0, 1'b0, 6, "R2 uncached block 0");
        miss(3, 15, 1'b0, -1, 0, 1'b0, 6, "R2 uncached block 15");
    endtask

    task automatic t_clean_steal;
        miss(2, 3, 1'b0, 1, 0, 1'b0, 7, "R3 clean steal from 1");
    endtask

    task automatic t_self_fault;
        miss(2, 3, 1'b1, -1, 0, 1'b1, 1, "R6 owner re-miss");
        // R6: entry unchanged, still owned by 2 and not modified
        miss(0, 3, 1'b1, 2, 0, 1'b0, 7, "R6 R5 entry after fault");
    endtask

    task automatic t_dirty_steal;
        miss(3, 3, 1'b0, 0, 1, 1'b0, 11, "R4 dirty steal from 0");
        miss(2, 3, 1'b0, 3, 0, 1'b0, 7, "R5 repointed to 3 clean");
    endtask

    task automatic t_independent;
        // R8: block 0 still owned by cache 0 modified, block 15 by cache 3 clean
        miss(1, 0, 1'b0, 0, 1, 1'b0, 11, "R8 block 0 intact");
        miss(1, 15, 1'b1, 3, 0, 1'b0, 7, "R8 block 15 intact");
        miss(2, 15, 1'b0, 1, 1, 1'b0, 11, "R5 block 15 modified by 1");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_uncached();
        t_clean_steal();
        t_self_fault();
        t_dirty_steal();
        t_independent();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule